// File: doc/BRIEF.md
# Inter-core auto-reset strobe fabric

This block carries attention signals between the cores of a sixteen-core processor. Each cycle, any core may issue a send that names one or more destination cores. It names them either with a destination mask or with a single destination index. The fabric turns every sender's request into a per-destination vector. For each receiver it ORs together the bits aimed at that receiver from all other cores, and it latches the result as the receiver's event.

A receiver consumes its event in one of two ways. A non-blocking get returns the event and a zero flag. A blocking wait raises its done output only once the event is present. Events clear themselves when they are consumed, unlike lock bits, which stay set until they are released explicitly. A strobe that lands in the same cycle as a clear is never lost.

A build parameter selects source tracking. In that mode each receiver keeps one bit per sender, so software can tell which cores strobed it. In this mode only a get clears the record. Each receiver also drives a one-cycle pulse when its event goes from empty to set, and this pulse can serve as an interrupt source.

Top module: `strobe_fabric`

## Requirements
- R1: After reset every receiver's event is empty: `get_zf` is 1 for every core, and `evt_pulse` and `wait_done` are 0.
- R2: A send with `send_imm`=0 uses the core's N-bit `send_mask` field, where bit k targets core k. A send issued in cycle T makes the targeted receivers' events visible in cycle T+1, and no other receiver changes.
- R3: A send with `send_imm`=1 targets only the single core whose number is given by that core's `send_idx` field (0 to 15).
- R4: A receiver targeted by several senders in the same cycle holds one event, which is the OR of all of them.
- R5: A core's own bit is ignored, so a core cannot strobe itself. A mask send with mask 0 changes no receiver.
- R6: `get_zf` is the inverse of "event present". In single-bit mode `get_data` bit 0 holds the event and all other bits are 0. A `get_req` in cycle T clears the event for cycle T+1.
- R7: If a new strobe reaches a receiver in the same cycle as its get or its consuming wait, the event stays set.
- R8: `wait_done` is 1 exactly in the cycles where `wait_req` is high and the event is present. In single-bit mode such a cycle consumes the event.
- R9: `evt_pulse` is high for one cycle, namely the first cycle in which the event is visible after being empty. A strobe that reaches an already-set event gives no pulse.
- R10: With `TRACK_SRC`=1, `get_data` bit s of a receiver is set when core s strobed it. `get_zf` is 1 when no bit is set. Only a get clears the vector; a wait leaves it intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_vld | input | NCORE | Per-core send request |
| send_imm | input | NCORE | Per-core addressing: 0 mask, 1 index |
| send_mask | input | NCORE*NCORE | Per-core destination mask, core c at [c*NCORE +: NCORE] |
| send_idx | input | NCORE*IDXW | Per-core destination index, core c at [c*IDXW +: IDXW] |
| get_req | input | NCORE | Per-core non-blocking get |
| wait_req | input | NCORE | Per-core blocking wait |
| get_data | output | NCORE*NCORE | Per-core event state, core c at [c*NCORE +: NCORE] |
| get_zf | output | NCORE | Per-core zero flag (no event present) |
| wait_done | output | NCORE | Per-core wait satisfied this cycle |
| evt_pulse | output | NCORE | Per-core one-cycle rise pulse |

## Verification
The hardest case to reach is a clear and a fresh strobe landing on the same receiver in the same cycle. The stimulus first parks an event at the receiver. In one cycle it then raises the receiver's get (or holds its wait) while a different core sends to that same receiver. It then checks that the event survives and that no second rise pulse appears. The source-tracking variant is a second instance driven by the same inputs. There, a wait held over a set vector must leave every sender bit in place until a later get.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int unsigned CORES_DEF = 16;

  typedef enum logic {
    ADDR_MASK  = 1'b0,
    ADDR_INDEX = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/strobe_encode.sv
module strobe_encode
  import strobe_pkg::*;
#(
  parameter int unsigned NCORE = CORES_DEF,
  parameter int unsigned SELF  = 0,
  localparam int unsigned IDXW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             send_vld,
  input  logic             send_imm,
  input  logic [NCORE-1:0] send_mask,
  input  logic [IDXW-1:0]  send_idx,
  output logic [NCORE-1:0] req
);
  logic [NCORE-1:0] idx_dec;
  logic [NCORE-1:0] sel;
  addr_mode_e       mode;

  assign mode = addr_mode_e'(send_imm);

  for (genvar i = 0; i < NCORE; i++) begin : g_dec
    assign idx_dec[i] = (send_idx == IDXW'(i));
  end

  always_comb begin
    sel = '0;
    if (send_vld) begin
      unique case (mode)
        ADDR_MASK:  sel = send_mask;
        ADDR_INDEX: sel = idx_dec;
        default:    sel = '0;
      endcase
    end
    req       = sel;
    req[SELF] = 1'b0;
  end
endmodule

// File: rtl/strobe_route.sv
module strobe_route #(
  parameter int unsigned NCORE = 16
) (
  input  logic [NCORE*NCORE-1:0] req_flat,
  output logic [NCORE*NCORE-1:0] rx_flat
);
  for (genvar r = 0; r < NCORE; r++) begin : g_rx
    for (genvar s = 0; s < NCORE; s++) begin : g_tx
      assign rx_flat[r*NCORE + s] = req_flat[s*NCORE + r];
    end
  end
endmodule

// File: rtl/strobe_rx.sv
module strobe_rx #(
  parameter int unsigned NCORE     = 16,
  parameter int unsigned SELF      = 0,
  parameter bit          TRACK_SRC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] in_vec,
  input  logic             get_req,
  input  logic             wait_req,
  output logic [NCORE-1:0] get_data,
  output logic             get_zf,
  output logic             wait_done,
  output logic             evt_pulse
);
  logic any_q;
  logic any_d;
  logic pulse_q;
  logic pulse_d;
  logic inc;

  assign inc = |in_vec;

  if (TRACK_SRC) begin : g_track
    logic [NCORE-1:0] src_q;
    logic [NCORE-1:0] src_d;
    logic             src_en;

    always_comb begin
      src_en = get_req | inc;
      src_d  = src_q;
      if (get_req) src_d = '0;
      src_d = src_d | in_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_q <= '0;
      else if (src_en) src_q <= src_d;
    end

    assign any_q    = |src_q;
    assign any_d    = |src_d;
    assign get_data = src_q;

    // R10: a wait without a get keeps every recorded sender bit
    p_wait_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !get_req) |=> ((src_q & $past(src_q)) == $past(src_q)));
    // R10: each sender bit arriving is recorded next cycle
    p_src_recorded_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> ((src_q & $past(in_vec)) == $past(in_vec)));
  end else begin : g_single
    logic ev_q;
    logic ev_d;
    logic ev_en;
    logic consume;

    always_comb begin
      consume = get_req | (wait_req & ev_q);
      ev_en   = consume | inc;
      ev_d    = (ev_q & ~consume) | inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ev_q <= 1'b0;
      else if (ev_en) ev_q <= ev_d;
    end

    assign any_q    = ev_q;
    assign any_d    = ev_d;
    assign get_data = {{(NCORE-1){1'b0}}, ev_q};

    // R8: a satisfied wait with no new strobe consumes the event
    p_wait_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_done && !inc) |=> !ev_q);
  end

  always_comb pulse_d = ~any_q & any_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign get_zf    = ~any_q;
  assign wait_done = wait_req & any_q;
  assign evt_pulse = pulse_q;

  // R2: one-cycle latency from arriving strobe to visible event
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> !get_zf);
  // R6: a get with no simultaneous strobe empties the receiver
  p_get_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (get_req && !inc) |=> get_zf);
  // R7: a get racing a new strobe keeps the event
  p_restrobe_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (get_req && inc) |=> !get_zf);
  // R9: the pulse only follows an empty cycle
  p_pulse_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (!get_zf && $past(get_zf)));
  // R5: the routing never hands a receiver its own request
  p_no_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vec[SELF]);
endmodule

// File: rtl/strobe_fabric.sv
module strobe_fabric
  import strobe_pkg::*;
#(
  parameter int unsigned NCORE     = CORES_DEF,
  parameter bit          TRACK_SRC = 1'b0,
  localparam int unsigned IDXW     = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE-1:0]       send_vld,
  input  logic [NCORE-1:0]       send_imm,
  input  logic [NCORE*NCORE-1:0] send_mask,
  input  logic [NCORE*IDXW-1:0]  send_idx,
  input  logic [NCORE-1:0]       get_req,
  input  logic [NCORE-1:0]       wait_req,
  output logic [NCORE*NCORE-1:0] get_data,
  output logic [NCORE-1:0]       get_zf,
  output logic [NCORE-1:0]       wait_done,
  output logic [NCORE-1:0]       evt_pulse
);
  logic [NCORE*NCORE-1:0] req_flat;
  logic [NCORE*NCORE-1:0] rx_flat;

  for (genvar c = 0; c < NCORE; c++) begin : g_enc
    strobe_encode #(.NCORE(NCORE), .SELF(c)) enc_i (
      .send_vld  (send_vld[c]),
      .send_imm  (send_imm[c]),
      .send_mask (send_mask[c*NCORE +: NCORE]),
      .send_idx  (send_idx[c*IDXW +: IDXW]),
      .req       (req_flat[c*NCORE +: NCORE])
    );
  end

  strobe_route #(.NCORE(NCORE)) route_i (
    .req_flat (req_flat),
    .rx_flat  (rx_flat)
  );

  for (genvar r = 0; r < NCORE; r++) begin : g_rx
    strobe_rx #(.NCORE(NCORE), .SELF(r), .TRACK_SRC(TRACK_SRC)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vec    (rx_flat[r*NCORE +: NCORE]),
      .get_req   (get_req[r]),
      .wait_req  (wait_req[r]),
      .get_data  (get_data[r*NCORE +: NCORE]),
      .get_zf    (get_zf[r]),
      .wait_done (wait_done[r]),
      .evt_pulse (evt_pulse[r])
    );
  end
endmodule

// File: tb/strobe_fabric_tb.sv
module strobe_fabric_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     send_vld, send_imm, get_req, wait_req;
  logic [N*N-1:0]   send_mask;
  logic [N*IW-1:0]  send_idx;
  logic [N*N-1:0]   gd_s, gd_t;
  logic [N-1:0]     zf_s, zf_t, wd_s, wd_t, ep_s, ep_t;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  strobe_fabric #(.NCORE(N), .TRACK_SRC(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_vld(send_vld), .send_imm(send_imm),
    .send_mask(send_mask), .send_idx(send_idx), .get_req(get_req),
    .wait_req(wait_req), .get_data(gd_s), .get_zf(zf_s),
    .wait_done(wd_s), .evt_pulse(ep_s));

  strobe_fabric #(.NCORE(N), .TRACK_SRC(1'b1)) dut_t (
    .clk(clk), .rst_n(rst_n), .send_vld(send_vld), .send_imm(send_imm),
    .send_mask(send_mask), .send_idx(send_idx), .get_req(get_req),
    .wait_req(wait_req), .get_data(gd_t), .get_zf(zf_t),
    .wait_done(wd_t), .evt_pulse(ep_t));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    send_vld = '0; send_imm = '0; send_mask = '0; send_idx = '0;
    get_req = '0; wait_req = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_m(input int src, input logic [N-1:0] m);
    send_vld[src] = 1'b1; send_imm[src] = 1'b0;
    send_mask[src*N +: N] = m;
  endtask

  task automatic send_i(input int src, input logic [IW-1:0] ix);
    send_vld[src] = 1'b1; send_imm[src] = 1'b1;
    send_idx[src*IW +: IW] = ix;
  endtask

  task automatic drain_all();
    idle(); get_req = '1; tick(); idle();
  endtask

  task automatic t_reset();
    chk(zf_s == '1 && zf_t == '1, "R1 zf", 32'(zf_s), 32'hffff);
    chk(ep_s == '0 && wd_s == '0, "R1 pulse/wait", 32'(ep_s), 0);
  endtask

  task automatic t_mask();
    send_m(3, 16'h00A1); tick(); idle();
    chk(~zf_s == 16'h00A1, "R2 mask targets", 32'(~zf_s), 32'h00A1);
    chk(ep_s == 16'h00A1, "R9 pulse on rise", 32'(ep_s), 32'h00A1);
    tick();
    chk(ep_s == '0, "R9 pulse one cycle", 32'(ep_s), 0);
    drain_all();
    chk(zf_s == '1, "R6 get clears all", 32'(zf_s), 32'hffff);
  endtask

  task automatic t_index();
    send_i(9, 4'd14); tick(); idle();
    chk(~zf_s == 16'h4000, "R3 index target", 32'(~zf_s), 32'h4000);
    drain_all();
    send_i(9, 4'd9); tick(); idle();
    chk(zf_s == '1, "R5 self index ignored", 32'(~zf_s), 0);
    send_m(2, 16'h0004); send_m(5, 16'h0000); tick(); idle();
    chk(zf_s == '1, "R5 own bit and zero mask", 32'(~zf_s), 0);
  endtask

  task automatic t_or();
    drain_all();
    send_m(1, 16'h0040); send_m(2, 16'h0040); tick(); idle();
    chk(~zf_s == 16'h0040, "R4 OR of senders", 32'(~zf_s), 32'h0040);
    chk(gd_t[6*N +: N] == 16'h0006, "R10 sender record",
        32'(gd_t[6*N +: N]), 32'h0006);
    get_req[6] = 1'b1; #1;
    chk(gd_s[6*N +: N] == 16'h0001 && !zf_s[6], "R6 get returns event",
        32'(gd_s[6*N +: N]), 1);
    tick(); idle();
    chk(zf_s[6] && zf_t[6], "R6 get consumed", 32'(zf_s[6]), 1);
  endtask

  task automatic t_race();
    send_m(0, 16'h0010); tick(); idle();
    get_req[4] = 1'b1; send_m(8, 16'h0010); tick(); idle();
    chk(!zf_s[4], "R7 get with restrobe keeps", 32'(zf_s[4]), 0);
    chk(!ep_s[4], "R9 no pulse when already set", 32'(ep_s[4]), 0);
    drain_all();
  endtask

  task automatic t_wait();
    wait_req[10] = 1'b1; #1;
    chk(!wd_s[10], "R8 wait stalls empty", 32'(wd_s[10]), 0);
    tick();
    chk(!wd_s[10], "R8 still stalled", 32'(wd_s[10]), 0);
    send_m(0, 16'h0400); tick(); send_vld = '0;
    chk(wd_s[10] && wd_t[10], "R8 wait satisfied", 32'(wd_s[10]), 1);
    tick();
    chk(zf_s[10] && !wd_s[10], "R8 wait consumed", 32'(zf_s[10]), 1);
    chk(!zf_t[10] && gd_t[10*N +: N] == 16'h0001, "R10 wait keeps record",
        32'(gd_t[10*N +: N]), 1);
    send_m(0, 16'h0400); tick(); send_vld = '0;
    send_m(11, 16'h0400); tick(); idle();
    chk(!zf_s[10], "R7 wait with restrobe keeps", 32'(zf_s[10]), 0);
    drain_all();
    chk(zf_t == '1 && gd_t == '0, "R10 get clears record", 32'(zf_t), 32'hffff);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_index();
    t_or();
    t_race();
    t_wait();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule